// File: doc/BRIEF.md
# Pilot-Driven Finger Channel Estimator

This block produces the complex channel gain for one multipath finger of a spread-spectrum receiver. It accepts despread common-pilot symbols, one per valid strobe, at a fixed pilot spreading factor of 256. That rate gives ten pilot symbols per slot and 150 per frame. Every pilot symbol is sent as 1+j, so the known modulation is removed by multiplying each received symbol by 1-j. This gives a raw estimate equal to twice the channel gain.

The raw estimates are smoothed by an equal-weight moving average over the last N pilots. The average is kept as a running sum: each accepted pilot adds its raw estimate and drops the one that leaves the window. N is a power of two, so the 1/N weight, together with the factor of two from derotation, becomes an arithmetic right shift. A short window follows fast fading more closely, and a long window gives a less noisy estimate. A final stage aligns the estimate to the traffic channel's spreading factor, which ranges from 4 to 512. For factors of 256 and below it repeats each estimate. For 512 it passes only every second estimate. No interpolation filter is used, because the channel drifts slowly compared with a symbol.

Top module: `pilot_chan_est`

## Requirements
- R1: Each accepted pilot (re, im) yields the raw estimate (re+im, im-re), carried one bit wider than the input.
- R2: Once the window is full, each output value equals floor(S/(2N)) per component, where S is the sum of the raw estimates of the last N accepted pilots.
- R3: Cycles with pil_valid low change neither the window nor the output, whatever pil_re and pil_im carry.
- R4: est_valid stays low until N pilots have been accepted since reset.
- R5: With sf_sel = k in 0..6 (traffic spreading factor 4·2^k), each estimate is repeated 64>>k times: est_valid is high for that many consecutive cycles, starting the cycle after the pilot edge.
- R6: With sf_sel = 7 (spreading factor 512), only the second of each pair of estimates is emitted, pairs counted from reset, each for one cycle.
- R7: An estimate that arrives while copies of the previous one are still being emitted replaces the value and restarts the copy count.
- R8: Reset empties the window and clears the output stage and the pairing phase.
- R9: While est_valid is high and no new estimate is loaded, est_re and est_im hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pil_valid | input | 1 | Pilot symbol strobe |
| pil_re | input | W | Pilot real part, signed |
| pil_im | input | W | Pilot imaginary part, signed |
| sf_sel | input | 3 | Traffic rate code: 0..6 selects spreading factor 4<<code, 7 selects 512 |
| est_valid | output | 1 | Traffic-rate estimate strobe |
| est_re | output | W | Channel estimate real part, signed |
| est_im | output | W | Channel estimate imaginary part, signed |

## Verification
The window update and the repeat stage can collide: a pilot can arrive on the very cycle the hold stage is still emitting copies of the previous estimate. The bench provokes this by sending two pilots on consecutive cycles at a code that asks for two copies. It expects the first value for one cycle, then the second value for two full cycles, then silence. Decimation is judged against the pair count from reset, and a 64-copy run is counted cycle by cycle while its value is held.

// File: rtl/chest_pkg.sv
package chest_pkg;
    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_DECIM = 3'd7;

    // Copies per pilot estimate for rate codes 0..6 (256 / (4 << code)).
    function automatic logic [6:0] rep_count(input logic [SEL_W-1:0] sel);
        return 7'd64 >> sel;
    endfunction
endpackage

// File: rtl/chest_derot.sv
module chest_derot #(
    parameter int W = 12
) (
    input  logic signed [W-1:0] in_re,
    input  logic signed [W-1:0] in_im,
    output logic signed [W:0]   raw_re,
    output logic signed [W:0]   raw_im
);
    localparam int RW = W + 1;

    // Multiply by the conjugate of 1+j: (a+jb)(1-j) = (a+b) + j(b-a)
    always_comb begin
        raw_re = RW'(in_re) + RW'(in_im);
        raw_im = RW'(in_im) - RW'(in_re);
    end
endmodule

// File: rtl/chest_smoother.sv
module chest_smoother #(
    parameter int W     = 12,
    parameter int LOG2N = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic signed [W:0]  in_re,
    input  logic signed [W:0]  in_im,
    output logic               ready,
    output logic               filled,
    output logic signed [W-1:0] avg_re,
    output logic signed [W-1:0] avg_im
);
    localparam int N  = 1 << LOG2N;
    localparam int RW = W + 1;
    localparam int SW = RW + LOG2N;
    localparam int SH = LOG2N + 1;
    localparam logic [LOG2N:0] FULL = (LOG2N + 1)'(N);

    typedef struct packed {
        logic signed [SW-1:0] sum_re;
        logic signed [SW-1:0] sum_im;
        logic [LOG2N-1:0]     ptr;
        logic [LOG2N:0]       fill;
    } win_t;

    win_t st_d, st_q;
    logic signed [RW-1:0] line_re_d [N];
    logic signed [RW-1:0] line_im_d [N];
    logic signed [RW-1:0] line_re_q [N];
    logic signed [RW-1:0] line_im_q [N];
    logic signed [SW-1:0] sh_re, sh_im;

    always_comb begin
        st_d      = st_q;
        line_re_d = line_re_q;
        line_im_d = line_im_q;
        ready     = 1'b0;
        if (in_valid) begin
            st_d.sum_re = st_q.sum_re + SW'(in_re) - SW'(line_re_q[st_q.ptr]);
            st_d.sum_im = st_q.sum_im + SW'(in_im) - SW'(line_im_q[st_q.ptr]);
            line_re_d[st_q.ptr] = in_re;
            line_im_d[st_q.ptr] = in_im;
            st_d.ptr = st_q.ptr + 1'b1;
            if (st_q.fill != FULL) begin
                st_d.fill = st_q.fill + 1'b1;
            end
            ready = (st_d.fill == FULL);
        end
        sh_re  = st_d.sum_re >>> SH;
        sh_im  = st_d.sum_im >>> SH;
        avg_re = sh_re[W-1:0];
        avg_im = sh_im[W-1:0];
        filled = (st_q.fill == FULL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < N; i++) begin
                line_re_q[i] <= '0;
                line_im_q[i] <= '0;
            end
        end else begin
            st_q      <= st_d;
            line_re_q <= line_re_d;
            line_im_q <= line_im_d;
        end
    end
endmodule

// File: rtl/chest_rate_hold.sv
module chest_rate_hold
    import chest_pkg::*;
#(
    parameter int W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic signed [W-1:0]  avg_re,
    input  logic signed [W-1:0]  avg_im,
    input  logic [SEL_W-1:0]     sel,
    output logic                 est_valid,
    output logic signed [W-1:0]  est_re,
    output logic signed [W-1:0]  est_im
);
    typedef struct packed {
        logic signed [W-1:0] val_re;
        logic signed [W-1:0] val_im;
        logic [6:0]          remain;
        logic                phase;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.remain != '0) begin
            st_d.remain = st_q.remain - 1'b1;
        end
        if (load) begin
            if (sel == SEL_DECIM) begin
                st_d.phase = ~st_q.phase;
                if (st_q.phase) begin
                    st_d.val_re = avg_re;
                    st_d.val_im = avg_im;
                    st_d.remain = 7'd1;
                end
            end else begin
                st_d.val_re = avg_re;
                st_d.val_im = avg_im;
                st_d.remain = rep_count(sel);
            end
        end
        est_valid = (st_q.remain != '0);
        est_re    = st_q.val_re;
        est_im    = st_q.val_im;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pilot_chan_est.sv
module pilot_chan_est
    import chest_pkg::*;
#(
    parameter int W     = 12,
    parameter int LOG2N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pil_valid,
    input  logic signed [W-1:0] pil_re,
    input  logic signed [W-1:0] pil_im,
    input  logic [2:0]          sf_sel,
    output logic                est_valid,
    output logic signed [W-1:0] est_re,
    output logic signed [W-1:0] est_im
);
    logic signed [W:0]   raw_re, raw_im;
    logic signed [W-1:0] avg_re, avg_im;
    logic                win_ready;
    logic                win_full;

    chest_derot #(.W(W)) u_derot (
        .in_re  (pil_re),
        .in_im  (pil_im),
        .raw_re (raw_re),
        .raw_im (raw_im)
    );

    chest_smoother #(.W(W), .LOG2N(LOG2N)) u_smooth (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (pil_valid),
        .in_re    (raw_re),
        .in_im    (raw_im),
        .ready    (win_ready),
        .filled   (win_full),
        .avg_re   (avg_re),
        .avg_im   (avg_im)
    );

    chest_rate_hold #(.W(W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (win_ready),
        .avg_re    (avg_re),
        .avg_im    (avg_im),
        .sel       (sf_sel),
        .est_valid (est_valid),
        .est_re    (est_re),
        .est_im    (est_im)
    );
endmodule

// File: rtl/pilot_chan_est_chk.sv
module pilot_chan_est_chk #(
    parameter int W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pil_valid,
    input logic [2:0]          sf_sel,
    input logic                win_ready,
    input logic                win_full,
    input logic                est_valid,
    input logic signed [W-1:0] est_re,
    input logic signed [W-1:0] est_im
);
    // R4
    no_early_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_full |-> !est_valid);

    // R5
    load_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_ready && sf_sel != 3'd7) |=> est_valid);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (est_valid && !win_ready) |=> (!est_valid || ($stable(est_re) && $stable(est_im))));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pil_valid && !est_valid) |=> !est_valid);
endmodule

bind pilot_chan_est pilot_chan_est_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pil_valid (pil_valid),
    .sf_sel    (sf_sel),
    .win_ready (win_ready),
    .win_full  (win_full),
    .est_valid (est_valid),
    .est_re    (est_re),
    .est_im    (est_im)
);

// File: tb/test_pilot_chan_est.sv
`timescale 1ns/1ps
module test_pilot_chan_est;
    localparam int W = 12;
    localparam int LOG2N = 4;
    localparam int N = 1 << LOG2N;
    localparam int NV = 24;

    // Each entry: {re[11:0], im[11:0]}
    localparam logic [23:0] VEC [NV] = '{
        24'h064_028, 24'h7FF_7FF, 24'h800_800, 24'h800_7FF,
        24'h123_F00, 24'hFFF_001, 24'h050_FB0, 24'h3A0_1C5,
        24'hC00_400, 24'h001_001, 24'h7FF_800, 24'h2B7_E49,
        24'h0F0_0F0, 24'hE10_E20, 24'h400_C00, 24'h0AA_155,
        24'h555_2AA, 24'hF3C_0C4, 24'h7C0_040, 24'h812_7EE,
        24'h000_000, 24'h1FF_E01, 24'h666_999, 24'hABC_123
    };

    logic clk = 1'b0;
    logic rst_n;
    logic pil_valid;
    logic signed [W-1:0] pil_re, pil_im;
    logic [2:0] sf_sel;
    logic est_valid;
    logic signed [W-1:0] est_re, est_im;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int hist_re [$];
    int hist_im [$];
    int accepted;
    int exp_re, exp_im;

    always #10 clk = ~clk;

    pilot_chan_est #(.W(W), .LOG2N(LOG2N)) i_pilot_chan_est (
        .clk(clk), .rst_n(rst_n), .pil_valid(pil_valid),
        .pil_re(pil_re), .pil_im(pil_im), .sf_sel(sf_sel),
        .est_valid(est_valid), .est_re(est_re), .est_im(est_im)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic model_push(input int re, input int im);
        int sr, si;
        hist_re.push_back(re + im);
        hist_im.push_back(im - re);
        if (hist_re.size() > N) begin
            void'(hist_re.pop_front());
            void'(hist_im.pop_front());
        end
        accepted++;
        sr = 0; si = 0;
        foreach (hist_re[i]) begin
            sr += hist_re[i];
            si += hist_im[i];
        end
        exp_re = sr >>> (LOG2N + 1);
        exp_im = si >>> (LOG2N + 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pil_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        hist_re.delete();
        hist_im.delete();
        accepted = 0;
    endtask

    // Drive one pilot; returns at the negedge after the accepting edge.
    task automatic send(input int re, input int im);
        @(negedge clk);
        pil_valid = 1'b1;
        pil_re = W'(re);
        pil_im = W'(im);
        model_push(re, im);
        @(negedge clk);
        pil_valid = 1'b0;
    endtask

    task automatic chk_est(input string req);
        chk(est_valid == 1'b1, req, int'(est_valid), 1);
        chk(int'(est_re) == exp_re, req, int'(est_re), exp_re);
        chk(int'(est_im) == exp_im, req, int'(est_im), exp_im);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int cnt;
        bit stable;
        int hr, hi;
        rst_n = 1'b0;
        pil_valid = 1'b0;
        pil_re = '0;
        pil_im = '0;
        sf_sel = 3'd6;
        accepted = 0;
        do_reset();

        // R8: reset state
        chk(est_valid == 1'b0, "R8 reset est_valid", int'(est_valid), 0);

        // Table walk at code 6 (one copy per estimate), R1/R2/R4/R3
        for (int i = 0; i < NV; i++) begin
            int vr, vi;
            vr = int'($signed(VEC[i][23:12]));
            vi = int'($signed(VEC[i][11:0]));
            send(vr, vi);
            if (accepted < N) begin
                chk(est_valid == 1'b0, "R4 early valid", int'(est_valid), 0);
            end else begin
                chk_est("R2 table window average");
            end
            // R3: junk on the data lines with the strobe low
            @(negedge clk);
            pil_re = 12'h5A5;
            pil_im = 12'hA5A;
            chk(est_valid == 1'b0, "R3 idle valid", int'(est_valid), 0);
        end

        // R1: constant pilot 100+j40 -> raw 140-j60 -> estimate 70-j30
        for (int i = 0; i < N; i++) send(100, 40);
        chk(int'(est_re) == 70, "R1 derot re", int'(est_re), 70);
        chk(int'(est_im) == -30, "R1 derot im", int'(est_im), -30);

        // R5/R9: code 0 gives 64 copies of a held value
        sf_sel = 3'd0;
        send(-300, 200);
        hr = int'(est_re);
        hi = int'(est_im);
        chk(hr == exp_re && hi == exp_im, "R5 copy value", hr, exp_re);
        cnt = 0;
        stable = 1'b1;
        while (est_valid && cnt < 100) begin
            cnt++;
            if (int'(est_re) != hr || int'(est_im) != hi) stable = 1'b0;
            @(negedge clk);
        end
        chk(cnt == 64, "R5 copy count code 0", cnt, 64);
        chk(stable, "R9 held value", int'(stable), 1);

        // R5: code 3 gives 8 copies
        sf_sel = 3'd3;
        send(7, -9);
        cnt = 0;
        while (est_valid && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == 8, "R5 copy count code 3", cnt, 8);

        // R7: back-to-back pilots at code 5 (two copies)
        sf_sel = 3'd5;
        @(negedge clk);
        pil_valid = 1'b1; pil_re = 12'sd500; pil_im = -12'sd120;
        model_push(500, -120);
        @(negedge clk);
        chk_est("R7 first value");
        pil_re = -12'sd250; pil_im = 12'sd333;
        model_push(-250, 333);
        @(negedge clk);
        pil_valid = 1'b0;
        chk_est("R7 reload copy 1");
        @(negedge clk);
        chk_est("R7 reload copy 2");
        @(negedge clk);
        chk(est_valid == 1'b0, "R7 run end", int'(est_valid), 0);

        // R8/R4: reset mid-stream empties the window
        do_reset();
        sf_sel = 3'd6;
        for (int i = 0; i < N - 1; i++) begin
            send(50 * i, -20 * i);
            chk(est_valid == 1'b0, "R8 window cleared", int'(est_valid), 0);
        end
        send(9, 9);
        chk_est("R4 first after fill");

        // R6: decimation, second of each pair from reset
        do_reset();
        sf_sel = 3'd7;
        for (int i = 0; i < N + 3; i++) begin
            send(30 + 11 * i, 400 - 17 * i);
            if (accepted == N + 1 || accepted == N + 3) begin
                chk_est("R6 decimated emit");
                @(negedge clk);
                chk(est_valid == 1'b0, "R6 one cycle only", int'(est_valid), 0);
            end else begin
                chk(est_valid == 1'b0, "R6 skipped estimate", int'(est_valid), 0);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule